// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block brings one DDR3 memory channel out of power-up and programs its mode registers. A single `start` pulse launches the sequence. The block holds the memory reset for a programmable time and then releases it. After a second wait it raises the clock enable. A final settling delay follows before the first command leaves the block.

Each command goes out on a valid/ready interface toward the channel's command scheduler. Every chip select in the presence mask receives four mode-register writes, in a fixed order. A ZQ long-calibration pair then closes the sequence, and `done` reports completion.

The mode-register words come from the timing inputs: CAS latency, CAS write latency, write recovery, burst control, precharge power-down exit mode, drive strength and the two termination codes. The block does not read these inputs from any registers. Ranks wired with mirrored address lines get their address and bank bits swapped before the command is issued.

Top module: `ddr3_init_seq`

## Requirements
- R1: After reset, `mem_reset_n`, `mem_cke`, `cmd_valid` and `done` are all 0.
- R2: The clock edge that takes `start` drives `mem_reset_n` low. It rises exactly RESET_HOLD_CYC cycles later. `mem_cke` rises exactly RESET_REL_CYC cycles after that. The first command becomes valid CKE_WAIT_CYC+1 cycles after the CKE rise. No command is valid while `mem_cke` or `mem_reset_n` is low.
- R3: Each targeted chip select receives mode-register writes (`cmd_type`=0) in the order MR2, MR3, MR1, MR0. The bank address carries the register number, with bank bit 2 at 0.
- R4: With `registered_dimm`=0, only the lowest present chip select is programmed. With `registered_dimm`=1, every present chip select is programmed, in ascending order. When no chip select is present, no mode-register write is sent.
- R5: MR0 holds the following fields:
  - bits 1:0 carry the burst control input.
  - bit 3 is 1 and bit 8 (DLL reset) is 1; bit 7 is 0.
  - bit 12 carries the power-down mode input.
  - The CAS code for CL 5..11 is 2·(CL−4). For CL 12..16 it is 2·(CL−12)+1. Code bits 3:1 go to address 6:4 and code bit 0 goes to address 2.
  - The write recovery code for WR 5,6,7,8,10,12,14,16 is 1,2,3,4,5,6,7,0, placed in address 11:9.
- R6: MR1 places the nominal termination code bit 2 at A9, bit 1 at A6 and bit 0 at A2. It places the drive code bit 1 at A5 and bit 0 at A1. All other bits are 0.
- R7: MR2 holds CWL−5 in bits 5:3, 1 in bit 7, 0 in bit 6 and the dynamic write termination code in bits 10:9. All other bits are 0. MR3 is all zero.
- R8: Mirroring applies to an odd chip select when `mirror_en`=1. The block then swaps address bits 3↔4, 5↔6 and 7↔8 and bank bits 0↔1 of each mode-register write.
- R9: After the mode-register writes, two ZQCL commands (`cmd_type`=1) are sent, each with `cmd_addr`=0x400 and `cmd_ba`=0. They go to the lowest present chip select, or to 0 when none is present. The second one becomes valid ZQ_WAIT_CYC+1 cycles after the first one is accepted.
- R10: A valid command holds all its fields until accepted (`cmd_valid`&&`cmd_ready` at a clock edge). Each acceptance consumes exactly one command.
- R11: `done` rises exactly ZQ_WAIT_CYC cycles after the second ZQCL is accepted and stays high until the next `start`. A `start` during the sequence has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch the power-up sequence |
| cs_present | input | NUM_CS | One bit per populated chip select |
| registered_dimm | input | 1 | 1: program every present chip select |
| mirror_en | input | 1 | Odd chip selects use mirrored address wiring |
| cfg_cl | input | 5 | CAS latency in clocks (5..16) |
| cfg_cwl | input | 4 | CAS write latency in clocks (5..12) |
| cfg_wr | input | 5 | Write recovery in clocks |
| cfg_burst | input | 2 | Burst length / control code |
| cfg_ppd | input | 1 | Precharge power-down exit mode |
| cfg_rtt_nom | input | 3 | Nominal termination code |
| cfg_rtt_wr | input | 2 | Dynamic write termination code |
| cfg_drv | input | 2 | Output drive strength code |
| mem_reset_n | output | 1 | Memory reset, active low |
| mem_cke | output | 1 | Memory clock enable |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Scheduler accepts the offered command |
| cmd_type | output | 1 | 0 = mode-register write, 1 = ZQCL |
| cmd_cs | output | CS_W | Target chip select |
| cmd_ba | output | 3 | Bank address |
| cmd_addr | output | ROW_W | Row address bus |
| done | output | 1 | Sequence complete |

## Verification
The assertions assume that the timing inputs, the presence mask and the mode inputs stay constant while a sequence runs. They also assume that `cmd_ready` may rise or fall in any cycle without any link to `cmd_valid`. The bench changes the configuration only while the block is idle or done. It drives `cmd_ready` from a free-running pseudo-random pattern, so commands are both stalled and accepted at once. The chosen CAS latency, CWL and write recovery values lie inside the legal encodings.

// File: rtl/ddr3i_pkg.sv
package ddr3i_pkg;

    localparam int unsigned BA_W = 3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RST_HOLD,
        ST_RST_REL,
        ST_CKE_WAIT,
        ST_MRS,
        ST_ZQ_ISSUE,
        ST_ZQ_WAIT,
        ST_DONE
    } seq_state_e;

    typedef enum logic {
        KIND_MRS  = 1'b0,
        KIND_ZQCL = 1'b1
    } cmd_kind_e;

    // Mode-register number written at each step of a chip-select group
    function automatic logic [1:0] mr_of_step(input logic [1:0] step);
        case (step)
            2'd0:    return 2'd2;
            2'd1:    return 2'd3;
            2'd2:    return 2'd1;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/ddr3i_wait_timer.sv
module ddr3i_wait_timer #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

    AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R2

endmodule

// File: rtl/ddr3i_mr_encode.sv
module ddr3i_mr_encode #(
    parameter int unsigned ROW_W = 16
) (
    input  logic [1:0]       mr_sel,
    input  logic [4:0]       cfg_cl,
    input  logic [3:0]       cfg_cwl,
    input  logic [4:0]       cfg_wr,
    input  logic [1:0]       cfg_burst,
    input  logic             cfg_ppd,
    input  logic [2:0]       cfg_rtt_nom,
    input  logic [1:0]       cfg_rtt_wr,
    input  logic [1:0]       cfg_drv,
    output logic [ROW_W-1:0] word
);

    logic [3:0] cas_code;
    logic [2:0] wr_code;
    logic [4:0] cl_off;
    logic       cl_high;
    logic [3:0] cwl_off;

    // CAS code: even codes for CL 5..11, odd codes for CL 12..16
    always_comb begin
        cl_high  = (cfg_cl >= 5'd12);
        cl_off   = cl_high ? (cfg_cl - 5'd12) : (cfg_cl - 5'd4);
        cas_code = {cl_off[2:0], cl_high};
        if (cfg_cl < 5'd5 || cfg_cl > 5'd16) begin
            cas_code = 4'd0;
        end
    end

    always_comb begin
        case (cfg_wr)
            5'd5:    wr_code = 3'd1;
            5'd6:    wr_code = 3'd2;
            5'd7:    wr_code = 3'd3;
            5'd8:    wr_code = 3'd4;
            5'd10:   wr_code = 3'd5;
            5'd12:   wr_code = 3'd6;
            5'd14:   wr_code = 3'd7;
            default: wr_code = 3'd0;
        endcase
    end

    assign cwl_off = cfg_cwl - 4'd5;

    always_comb begin
        word = '0;
        case (mr_sel)
            2'd0: begin
                word[1:0]  = cfg_burst;
                word[2]    = cas_code[0];
                word[3]    = 1'b1;
                word[6:4]  = cas_code[3:1];
                word[7]    = 1'b0;
                word[8]    = 1'b1;
                word[11:9] = wr_code;
                word[12]   = cfg_ppd;
            end
            2'd1: begin
                word[1] = cfg_drv[0];
                word[2] = cfg_rtt_nom[0];
                word[5] = cfg_drv[1];
                word[6] = cfg_rtt_nom[1];
                word[9] = cfg_rtt_nom[2];
            end
            2'd2: begin
                word[5:3]  = cwl_off[2:0];
                word[6]    = 1'b0;
                word[7]    = 1'b1;
                word[10:9] = cfg_rtt_wr;
            end
            default: word = '0;
        endcase
    end

endmodule

// File: rtl/ddr3i_addr_mirror.sv
module ddr3i_addr_mirror #(
    parameter int unsigned ROW_W = 16,
    parameter int unsigned BA_W  = 3,
    parameter int unsigned PAIRS = 3
) (
    input  logic             enable,
    input  logic [ROW_W-1:0] addr_in,
    input  logic [BA_W-1:0]  ba_in,
    output logic [ROW_W-1:0] addr_out,
    output logic [BA_W-1:0]  ba_out
);

    localparam int unsigned FIRST_BIT = 3;

    always_comb begin
        addr_out = addr_in;
        ba_out   = ba_in;
        if (enable) begin
            for (int k = 0; k < int'(PAIRS); k++) begin
                addr_out[FIRST_BIT + 2*k]     = addr_in[FIRST_BIT + 2*k + 1];
                addr_out[FIRST_BIT + 2*k + 1] = addr_in[FIRST_BIT + 2*k];
            end
            ba_out[0] = ba_in[1];
            ba_out[1] = ba_in[0];
        end
    end

endmodule

// File: rtl/ddr3_init_seq.sv
module ddr3_init_seq
    import ddr3i_pkg::*;
#(
    parameter int unsigned NUM_CS         = 8,
    parameter int unsigned ROW_W          = 16,
    parameter int unsigned RESET_HOLD_CYC = 10000,
    parameter int unsigned RESET_REL_CYC  = 25000,
    parameter int unsigned CKE_WAIT_CYC   = 18,
    parameter int unsigned ZQ_WAIT_CYC    = 512,
    localparam int unsigned CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NUM_CS-1:0] cs_present,
    input  logic              registered_dimm,
    input  logic              mirror_en,
    input  logic [4:0]        cfg_cl,
    input  logic [3:0]        cfg_cwl,
    input  logic [4:0]        cfg_wr,
    input  logic [1:0]        cfg_burst,
    input  logic              cfg_ppd,
    input  logic [2:0]        cfg_rtt_nom,
    input  logic [1:0]        cfg_rtt_wr,
    input  logic [1:0]        cfg_drv,
    output logic              mem_reset_n,
    output logic              mem_cke,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic              cmd_type,
    output logic [CS_W-1:0]   cmd_cs,
    output logic [2:0]        cmd_ba,
    output logic [ROW_W-1:0]  cmd_addr,
    output logic              done
);

    localparam int unsigned MAX_A    = (RESET_HOLD_CYC > RESET_REL_CYC) ? RESET_HOLD_CYC : RESET_REL_CYC;
    localparam int unsigned MAX_B    = (CKE_WAIT_CYC > ZQ_WAIT_CYC) ? CKE_WAIT_CYC : ZQ_WAIT_CYC;
    localparam int unsigned MAX_WAIT = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned CNT_W    = $clog2(MAX_WAIT + 1);
    localparam int unsigned ZQ_BIT   = 10;

    localparam logic [CNT_W-1:0] LD_HOLD = CNT_W'(RESET_HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] LD_REL  = CNT_W'(RESET_REL_CYC - 1);
    localparam logic [CNT_W-1:0] LD_CKE  = CNT_W'(CKE_WAIT_CYC - 1);
    localparam logic [CNT_W-1:0] LD_ZQ   = CNT_W'(ZQ_WAIT_CYC - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [CS_W-1:0]   cs;
        logic [1:0]        step;
        logic              zq_second;
        logic              rst_out_n;
        logic              cke;
        logic              vld;
        logic              kind;
        logic [CS_W-1:0]   ocs;
        logic [BA_W-1:0]   oba;
        logic [ROW_W-1:0]  oaddr;
        logic              done;
    } seq_regs_t;

    seq_regs_t d, q;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;

    logic [CS_W-1:0]  first_cs, next_cs;
    logic             first_ok, next_ok;
    logic [1:0]       mr_num;
    logic [ROW_W-1:0] mr_word;
    logic [ROW_W-1:0] mir_addr;
    logic [BA_W-1:0]  mir_ba;
    logic             mir_on;

    // Lowest present chip select, and lowest present one above the current
    always_comb begin
        first_cs = '0;
        first_ok = 1'b0;
        next_cs  = '0;
        next_ok  = 1'b0;
        for (int i = int'(NUM_CS) - 1; i >= 0; i--) begin
            if (cs_present[i]) begin
                first_cs = CS_W'(i);
                first_ok = 1'b1;
                if (CS_W'(i) > q.cs) begin
                    next_cs = CS_W'(i);
                    next_ok = 1'b1;
                end
            end
        end
    end

    assign mr_num = mr_of_step(q.step);
    assign mir_on = mirror_en & q.cs[0];

    ddr3i_mr_encode #(
        .ROW_W (ROW_W)
    ) u_encode (
        .mr_sel      (mr_num),
        .cfg_cl      (cfg_cl),
        .cfg_cwl     (cfg_cwl),
        .cfg_wr      (cfg_wr),
        .cfg_burst   (cfg_burst),
        .cfg_ppd     (cfg_ppd),
        .cfg_rtt_nom (cfg_rtt_nom),
        .cfg_rtt_wr  (cfg_rtt_wr),
        .cfg_drv     (cfg_drv),
        .word        (mr_word)
    );

    ddr3i_addr_mirror #(
        .ROW_W (ROW_W),
        .BA_W  (BA_W),
        .PAIRS (3)
    ) u_mirror (
        .enable   (mir_on),
        .addr_in  (mr_word),
        .ba_in    ({1'b0, mr_num}),
        .addr_out (mir_addr),
        .ba_out   (mir_ba)
    );

    ddr3i_wait_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    always_comb begin
        d        = q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (q.st)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    d.st        = ST_RST_HOLD;
                    d.rst_out_n = 1'b0;
                    d.cke       = 1'b0;
                    d.done      = 1'b0;
                    tmr_load    = 1'b1;
                    tmr_val     = LD_HOLD;
                end
            end
            ST_RST_HOLD: begin
                if (tmr_expired) begin
                    d.st        = ST_RST_REL;
                    d.rst_out_n = 1'b1;
                    tmr_load    = 1'b1;
                    tmr_val     = LD_REL;
                end
            end
            ST_RST_REL: begin
                if (tmr_expired) begin
                    d.st     = ST_CKE_WAIT;
                    d.cke    = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = LD_CKE;
                end
            end
            ST_CKE_WAIT: begin
                if (tmr_expired) begin
                    d.step      = 2'd0;
                    d.zq_second = 1'b0;
                    d.cs        = first_cs;
                    d.st        = first_ok ? ST_MRS : ST_ZQ_ISSUE;
                end
            end
            ST_MRS: begin
                if (!q.vld) begin
                    d.vld   = 1'b1;
                    d.kind  = KIND_MRS;
                    d.ocs   = q.cs;
                    d.oba   = mir_ba;
                    d.oaddr = mir_addr;
                end else if (cmd_ready) begin
                    d.vld = 1'b0;
                    if (q.step == 2'd3) begin
                        d.step = 2'd0;
                        if (registered_dimm && next_ok) begin
                            d.cs = next_cs;
                        end else begin
                            d.st = ST_ZQ_ISSUE;
                        end
                    end else begin
                        d.step = q.step + 2'd1;
                    end
                end
            end
            ST_ZQ_ISSUE: begin
                if (!q.vld) begin
                    d.vld           = 1'b1;
                    d.kind          = KIND_ZQCL;
                    d.ocs           = first_cs;
                    d.oba           = '0;
                    d.oaddr         = '0;
                    d.oaddr[ZQ_BIT] = 1'b1;
                end else if (cmd_ready) begin
                    d.vld    = 1'b0;
                    d.st     = ST_ZQ_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = LD_ZQ;
                end
            end
            ST_ZQ_WAIT: begin
                if (tmr_expired) begin
                    if (q.zq_second) begin
                        d.st   = ST_DONE;
                        d.done = 1'b1;
                    end else begin
                        d.st        = ST_ZQ_ISSUE;
                        d.zq_second = 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign mem_reset_n = q.rst_out_n;
    assign mem_cke     = q.cke;
    assign cmd_valid   = q.vld;
    assign cmd_type    = q.kind;
    assign cmd_cs      = q.ocs;
    assign cmd_ba      = q.oba;
    assign cmd_addr    = q.oaddr;
    assign done        = q.done;

    AST_CMD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable({cmd_type, cmd_cs, cmd_ba, cmd_addr}))); // R10
    AST_NO_CMD_WITHOUT_CKE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (mem_cke && mem_reset_n)); // R2
    AST_CKE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cke |-> mem_reset_n); // R2
    AST_MR3_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_type && cmd_ba == 3'd3) |-> (cmd_addr == '0)); // R7
    AST_ZQ_A10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_type) |-> (cmd_addr == ROW_W'(1 << ZQ_BIT) && cmd_ba == 3'd0)); // R9
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cmd_valid); // R11

endmodule

// File: tb/ddr3_init_seq_bench.sv
module ddr3_init_seq_bench;

    localparam int RH = 20;
    localparam int RR = 30;
    localparam int CW = 4;
    localparam int ZQ = 16;

    typedef struct packed {
        logic        kind;
        logic [2:0]  cs;
        logic [2:0]  ba;
        logic [15:0] addr;
    } cmd_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [7:0] cs_present = 8'h00;
    logic registered_dimm = 1'b0;
    logic mirror_en = 1'b0;
    logic [4:0] cfg_cl = 5'd5;
    logic [3:0] cfg_cwl = 4'd5;
    logic [4:0] cfg_wr = 5'd5;
    logic [1:0] cfg_burst = 2'd0;
    logic cfg_ppd = 1'b0;
    logic [2:0] cfg_rtt_nom = 3'd0;
    logic [1:0] cfg_rtt_wr = 2'd0;
    logic [1:0] cfg_drv = 2'd0;
    logic cmd_ready = 1'b0;
    logic mem_reset_n, mem_cke, cmd_valid, cmd_type, done;
    logic [2:0] cmd_cs, cmd_ba;
    logic [15:0] cmd_addr;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    cmd_t exp_q[$];

    // event bookkeeping filled by the monitor
    int start_edge, rst_rise, cke_rise, first_vld, zq1_acc, zq2_vld, zq2_acc, done_rise;
    int zq_seen;
    logic seen_vld;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ddr3_init_seq #(
        .NUM_CS(8), .ROW_W(16), .RESET_HOLD_CYC(RH), .RESET_REL_CYC(RR),
        .CKE_WAIT_CYC(CW), .ZQ_WAIT_CYC(ZQ)
    ) u_ddr3_init_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cs_present(cs_present),
        .registered_dimm(registered_dimm), .mirror_en(mirror_en),
        .cfg_cl(cfg_cl), .cfg_cwl(cfg_cwl), .cfg_wr(cfg_wr), .cfg_burst(cfg_burst),
        .cfg_ppd(cfg_ppd), .cfg_rtt_nom(cfg_rtt_nom), .cfg_rtt_wr(cfg_rtt_wr),
        .cfg_drv(cfg_drv), .mem_reset_n(mem_reset_n), .mem_cke(mem_cke),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_type(cmd_type),
        .cmd_cs(cmd_cs), .cmd_ba(cmd_ba), .cmd_addr(cmd_addr), .done(done)
    );

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // ---------------- reference encodings written from the requirements
    function automatic logic [3:0] ref_cas(input int cl);
        case (cl)
            5: return 4'd2;   6: return 4'd4;   7: return 4'd6;   8: return 4'd8;
            9: return 4'd10;  10: return 4'd12; 11: return 4'd14; 12: return 4'd1;
            13: return 4'd3;  14: return 4'd5;  15: return 4'd7;  16: return 4'd9;
            default: return 4'd0;
        endcase
    endfunction

    function automatic logic [2:0] ref_wr(input int wr);
        case (wr)
            5: return 3'd1; 6: return 3'd2; 7: return 3'd3; 8: return 3'd4;
            10: return 3'd5; 12: return 3'd6; 14: return 3'd7;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic [15:0] ref_word(input int mr);
        logic [15:0] w;
        logic [3:0] c;
        w = '0;
        c = ref_cas(int'(cfg_cl));
        if (mr == 0) begin           // R5
            w[1:0] = cfg_burst; w[3] = 1'b1; w[8] = 1'b1;
            w[6:4] = c[3:1]; w[2] = c[0];
            w[11:9] = ref_wr(int'(cfg_wr)); w[12] = cfg_ppd;
        end else if (mr == 1) begin  // R6
            w[9] = cfg_rtt_nom[2]; w[6] = cfg_rtt_nom[1]; w[2] = cfg_rtt_nom[0];
            w[5] = cfg_drv[1]; w[1] = cfg_drv[0];
        end else if (mr == 2) begin  // R7
            w[5:3] = 3'(cfg_cwl - 4'd5); w[7] = 1'b1; w[10:9] = cfg_rtt_wr;
        end
        return w;
    endfunction

    // R8 reference swap
    function automatic cmd_t ref_mirror(input cmd_t c);
        cmd_t m;
        m = c;
        m.addr[3] = c.addr[4]; m.addr[4] = c.addr[3];
        m.addr[5] = c.addr[6]; m.addr[6] = c.addr[5];
        m.addr[7] = c.addr[8]; m.addr[8] = c.addr[7];
        m.ba[0] = c.ba[1]; m.ba[1] = c.ba[0];
        return m;
    endfunction

    // Driver: push the expected command stream for the current configuration
    task automatic push_expected();
        int order[4] = '{2, 3, 1, 0};
        int first = -1;
        cmd_t c;
        for (int i = 0; i < 8; i++) begin
            if (cs_present[i] && first < 0) first = i;
        end
        for (int i = 0; i < 8; i++) begin
            if (cs_present[i] && (registered_dimm || i == first)) begin // R4
                for (int s = 0; s < 4; s++) begin                       // R3
                    c.kind = 1'b0;
                    c.cs = 3'(i);
                    c.ba = 3'(order[s]);
                    c.addr = ref_word(order[s]);
                    if (mirror_en && (i % 2 == 1)) c = ref_mirror(c);
                    exp_q.push_back(c);
                end
            end
        end
        for (int z = 0; z < 2; z++) begin                               // R9
            c.kind = 1'b1;
            c.cs = (first < 0) ? 3'd0 : 3'(first);
            c.ba = 3'd0;
            c.addr = 16'h0400;
            exp_q.push_back(c);
        end
    endtask

    // Ready pattern: pseudo-random stalls
    initial begin
        logic [7:0] lfsr = 8'hA5;
        forever begin
            @(negedge clk);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            cmd_ready = lfsr[0] | lfsr[2];
        end
    end

    // Monitor / scoreboard
    initial begin
        logic p_rst = 1'b0, p_cke = 1'b0, p_vld = 1'b0, p_rdy = 1'b0, p_done = 1'b0;
        cmd_t p_cmd = '0;
        cmd_t got, exp;
        forever begin
            @(negedge clk);
            got = '{kind: cmd_type, cs: cmd_cs, ba: cmd_ba, addr: cmd_addr};
            if (rst_n) begin
                if (p_vld && !p_rdy) // R10: held until accepted
                    chk(cmd_valid && got == p_cmd, "R10", longint'(got), longint'(p_cmd));
                if (!p_rst && mem_reset_n) rst_rise = cyc;
                if (!p_cke && mem_cke) cke_rise = cyc;
                if (cmd_valid && !seen_vld) begin
                    first_vld = cyc;
                    seen_vld = 1'b1;
                end
                if (!p_vld && cmd_valid && cmd_type && zq_seen == 1) zq2_vld = cyc;
                if (!p_done && done) done_rise = cyc;
                if (cmd_valid && cmd_ready) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R3 unexpected command", longint'(got), 0);
                    end else begin
                        exp = exp_q.pop_front();
                        chk(got == exp, "R3/R4/R5/R6/R7/R8/R9 command", longint'(got), longint'(exp));
                    end
                    if (cmd_type) begin
                        if (zq_seen == 0) zq1_acc = cyc + 1;
                        else zq2_acc = cyc + 1;
                        zq_seen++;
                    end
                end
            end
            p_rst = mem_reset_n; p_cke = mem_cke; p_vld = cmd_valid;
            p_rdy = cmd_ready; p_done = done; p_cmd = got;
        end
    end

    task automatic run(input logic poke_start);
        exp_q.delete();
        push_expected();
        rst_rise = -1; cke_rise = -1; first_vld = -1; zq1_acc = -1;
        zq2_vld = -1; zq2_acc = -1; done_rise = -1; zq_seen = 0; seen_vld = 1'b0;
        @(negedge clk);
        start = 1'b1;
        start_edge = cyc + 1;
        @(negedge clk);
        start = 1'b0;
        chk(!mem_reset_n && !mem_cke && !done, "R2 reset asserted on start",
            longint'({mem_reset_n, mem_cke, done}), 0);
        if (poke_start) begin // R11: start while busy ignored
            repeat (RH + RR + CW + 6) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        chk(rst_rise - start_edge == RH, "R2 reset hold", rst_rise - start_edge, RH);
        chk(cke_rise - rst_rise == RR, "R2 cke delay", cke_rise - rst_rise, RR);
        chk(first_vld - cke_rise == CW + 1, "R2 first command delay", first_vld - cke_rise, CW + 1);
        chk(zq2_vld - zq1_acc == ZQ + 1, "R9 zq gap", zq2_vld - zq1_acc, ZQ + 1);
        chk(done_rise - zq2_acc == ZQ, "R11 done delay", done_rise - zq2_acc, ZQ);
        chk(exp_q.size() == 0, "R4 all expected commands seen", exp_q.size(), 0);
        repeat (10) @(negedge clk);
        chk(done && !cmd_valid && mem_cke && mem_reset_n, "R11 done held",
            longint'({done, cmd_valid, mem_cke, mem_reset_n}), 4'hB);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(!mem_reset_n && !mem_cke && !cmd_valid && !done, "R1 reset state",
            longint'({mem_reset_n, mem_cke, cmd_valid, done}), 0);

        // Run A: unbuffered, first present CS is odd and mirrored
        cs_present = 8'b0000_0110; registered_dimm = 1'b0; mirror_en = 1'b1;
        cfg_cl = 5'd5; cfg_cwl = 4'd5; cfg_wr = 5'd16; cfg_burst = 2'd2; cfg_ppd = 1'b1;
        cfg_rtt_nom = 3'b101; cfg_rtt_wr = 2'd2; cfg_drv = 2'b01;
        run(1'b0);

        // Run B: registered, mixed mirrored ranks, start poked mid-run
        cs_present = 8'b1010_0001; registered_dimm = 1'b1; mirror_en = 1'b1;
        cfg_cl = 5'd12; cfg_cwl = 4'd9; cfg_wr = 5'd5; cfg_burst = 2'd0; cfg_ppd = 1'b0;
        cfg_rtt_nom = 3'b010; cfg_rtt_wr = 2'd1; cfg_drv = 2'b10;
        run(1'b1);

        // Run C: registered, mirroring off
        cs_present = 8'b0000_0011; registered_dimm = 1'b1; mirror_en = 1'b0;
        cfg_cl = 5'd16; cfg_cwl = 4'd12; cfg_wr = 5'd14; cfg_burst = 2'd1; cfg_ppd = 1'b1;
        cfg_rtt_nom = 3'b111; cfg_rtt_wr = 2'd3; cfg_drv = 2'b11;
        run(1'b0);

        // Run D: unbuffered, CL 11 / WR 10
        cs_present = 8'b0001_0000; registered_dimm = 1'b0; mirror_en = 1'b1;
        cfg_cl = 5'd11; cfg_cwl = 4'd7; cfg_wr = 5'd10; cfg_burst = 2'd3; cfg_ppd = 1'b0;
        cfg_rtt_nom = 3'b001; cfg_rtt_wr = 2'd0; cfg_drv = 2'b00;
        run(1'b0);

        // Run E: nothing present, only the ZQCL pair
        cs_present = 8'b0000_0000; registered_dimm = 1'b1;
        run(1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule